// File: doc/BRIEF.md
# Converter Result Holding Registers with Read Interlock

This block keeps the most recent 10-bit result from an analog-to-digital converter and lets a CPU read it as two bytes, a low byte and a high byte, over a simple read bus. An adjust-select input sets how the 10 bits are placed across the two bytes. With left placement, the eight most significant bits land in the high byte, so software that needs only 8 bits reads the high byte alone.

A full-precision read takes the low byte first and then the high byte. When the low byte is read, the stored result is frozen. Any conversion that completes while it is frozen is discarded. Reading the high byte releases the freeze. This guarantees that the two bytes a CPU collects always come from one conversion. Every completion raises a conversion-done flag, including completions whose data was discarded. Software clears the flag through a clear input.

Top module: `adc_result_latch`

## Requirements
- R1: After reset the block is unfrozen, the stored result is zero, `rd_data` is zero and `irq_flag` is low.
- R2: With `left_adj`=0, a low-byte read (`rd_sel`=0) returns result bits 7:0. A high-byte read (`rd_sel`=1) returns bits 9:8 in positions 1:0, and positions 7:2 read zero.
- R3: With `left_adj`=1, a high-byte read returns result bits 9:2. A low-byte read returns bits 1:0 in positions 7:6, and positions 5:0 read zero.
- R4: The placement is applied when the stored result is read. Changing `left_adj` changes how the result already held is presented.
- R5: A low-byte read freezes the stored result. A completion in the same cycle as that read, or in any later cycle before the next high-byte read, leaves both bytes unchanged and its data is lost.
- R6: A high-byte read returns the value held before that cycle and releases the freeze. A completion in the same cycle as the high-byte read is stored.
- R7: A high-byte read with no low-byte read before it is allowed and leaves the block unfrozen.
- R8: `irq_flag` is high in the cycle after any cycle with `conv_valid`=1, whether or not the data was stored.
- R9: `irq_clr`=1 clears `irq_flag` on the next cycle. If `conv_valid` and `irq_clr` are both high in the same cycle, the flag is set.
- R10: `rd_data` is registered. It shows the selected byte one cycle after `rd_en` and holds that value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data | input | 10 | Result of the finished conversion |
| left_adj | input | 1 | 1 = left placement, 0 = right placement |
| rd_en | input | 1 | Read request for this cycle |
| rd_sel | input | 1 | Byte to read: 0 = low, 1 = high |
| rd_data | output | 8 | Registered read data |
| irq_clr | input | 1 | Clear the conversion-done flag |
| irq_flag | output | 1 | Conversion-done flag |

## Verification
The in-RTL assertions check, on every cycle, the behaviour that holds cycle by cycle:
- the freeze is entered on a low-byte read and left on a high-byte read;
- the stored result stays fixed while frozen;
- the flag is set after each completion, and a clear without a completion takes effect;
- the zero-filled positions of each placement are zero;
- `rd_data` holds between reads.

Other behaviour shows only across a sequence of bench transactions: that the two bytes read in a frozen pair come from one conversion, that discarded data is truly lost and a later read still shows the older value, that a completion at the exact cycle of a high-byte read is kept, and that switching the placement reinterprets the result already held.

// File: rtl/adc_rl_pkg.sv
package adc_rl_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/adc_rl_lock.sv
module adc_rl_lock (
  input  logic clk,
  input  logic rst,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic locked
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst)        lock_q <= 1'b0;
    else if (rd_hi) lock_q <= 1'b0;
    else if (rd_lo) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  // R5: a low-byte read enters the freeze
  a_r5_lock_on_low: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> locked);
  // R6: a high-byte read leaves the freeze
  a_r6_unlock_on_high: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> !locked);
  // R7: without a low-byte read, an unfrozen block stays unfrozen
  a_r7_stay_open: assert property (@(posedge clk) disable iff (rst)
    (!locked && !rd_lo) |=> !locked);
endmodule

// File: rtl/adc_rl_irq.sv
module adc_rl_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R8: every completion raises the flag; R9: set has priority over clear
  a_r8_set_on_done: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag);
  // R9: a clear without a completion drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag);
endmodule

// File: rtl/adc_rl_format.sv
module adc_rl_format #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    if (left) word[WORD_W-1 -: RES_W] = res;
    else      word[RES_W-1:0]         = res;
  end

  assign lo_byte = word[BYTE_W-1:0];
  assign hi_byte = word[WORD_W-1:BYTE_W];
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              left_adj,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              irq_clr,
  output logic              irq_flag
);
  import adc_rl_pkg::*;

  localparam int PAD_W  = 2 * BYTE_W - RES_W;
  localparam int HI_USE = RES_W - BYTE_W;

  logic              rd_lo, rd_hi, locked, upd;
  logic [RES_W-1:0]  res_q;
  logic [BYTE_W-1:0] lo_b, hi_b, rd_q;

  assign rd_lo = rd_en && (rd_sel == SEL_LO);
  assign rd_hi = rd_en && (rd_sel == SEL_HI);
  assign upd   = conv_valid && !rd_lo && (!locked || rd_hi);

  adc_rl_lock u_lock (
    .clk    (clk),
    .rst    (rst),
    .rd_lo  (rd_lo),
    .rd_hi  (rd_hi),
    .locked (locked)
  );

  adc_rl_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .set_i (conv_valid),
    .clr_i (irq_clr),
    .flag  (irq_flag)
  );

  adc_rl_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .res     (res_q),
    .left    (left_adj),
    .lo_byte (lo_b),
    .hi_byte (hi_b)
  );

  always_ff @(posedge clk) begin
    if (rst)      res_q <= '0;
    else if (upd) res_q <= conv_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_hi ? hi_b : lo_b;
  end

  assign rd_data = rd_q;

  // R5: while frozen (and not released this cycle) the result is held
  a_r5_hold_locked: assert property (@(posedge clk) disable iff (rst)
    (locked && !rd_hi) |=> $stable(res_q));
  // R5: a completion coinciding with a low-byte read is dropped
  a_r5_drop_same_cycle: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> $stable(res_q));
  // R6: an unfrozen completion is stored
  a_r6_store_open: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !locked && !rd_lo) |=> (res_q == $past(conv_data)));
  // R2: right placement leaves the unused high-byte positions zero
  a_r2_hi_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (rd_hi && !left_adj) |=> (rd_data[BYTE_W-1:HI_USE] == '0));
  // R3: left placement leaves the unused low-byte positions zero
  a_r3_lo_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && left_adj) |=> (rd_data[PAD_W-1:0] == '0));
  // R10: read data holds between reads
  a_r10_hold_data: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/adc_result_latch_bench.sv
`timescale 1ns/1ps
module adc_result_latch_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_valid = 1'b0;
  logic [9:0] conv_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       irq_clr = 1'b0;
  logic       irq_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #2.5 clk = ~clk;

  adc_result_latch u_adc_result_latch (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .left_adj(left_adj), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_clr(irq_clr), .irq_flag(irq_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result one cycle after its request
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data == e, t, rd_data, e);
    end
  end

  // driver: one read, optionally with a completion in the same cycle
  task automatic rd(input bit sel, input logic [7:0] exp, input string tag,
                    input bit with_conv = 0, input logic [9:0] cdata = '0);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    if (with_conv) begin conv_valid = 1'b1; conv_data = cdata; end
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; conv_valid = 1'b0;
  endtask

  task automatic conv(input logic [9:0] d, input bit clr = 0);
    @(negedge clk);
    conv_valid = 1'b1; conv_data = d; irq_clr = clr;
    @(negedge clk);
    conv_valid = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
    check(irq_flag == 1'b0, "R1 irq after reset", irq_flag, 0);
    rd(1'b0, 8'h00, "R1 low byte after reset");
    rd(1'b1, 8'h00, "R1 high byte after reset");

    left_adj = 1'b0;
    conv(10'h2A5);
    check(irq_flag == 1'b1, "R8 flag after completion", irq_flag, 1);
    rd(1'b0, 8'hA5, "R2 right low");
    rd(1'b1, 8'h02, "R2 right high");

    @(negedge clk); left_adj = 1'b1;
    rd(1'b1, 8'hA9, "R3 R4 left high alone, R7");
    rd(1'b0, 8'h40, "R3 left low");
    rd(1'b1, 8'hA9, "R3 left high");

    clear_irq();
    check(irq_flag == 1'b0, "R9 clear", irq_flag, 0);
    conv(10'h155, 1'b1);
    check(irq_flag == 1'b1, "R9 set wins over clear", irq_flag, 1);

    @(negedge clk); left_adj = 1'b0;
    rd(1'b0, 8'h55, "R5 low read freezes");
    clear_irq();
    conv(10'h3FF);
    check(irq_flag == 1'b1, "R8 flag on dropped result", irq_flag, 1);
    rd(1'b1, 8'h01, "R5 high after dropped result");
    rd(1'b0, 8'h55, "R5 low still old");
    rd(1'b1, 8'h01, "R5 high still old");

    rd(1'b0, 8'h55, "R5 low read with same-cycle completion", 1'b1, 10'h0F0);
    rd(1'b1, 8'h01, "R5 same-cycle completion dropped");

    rd(1'b0, 8'h55, "R6 low read before release");
    rd(1'b1, 8'h01, "R6 high returns prior value", 1'b1, 10'h2C3);
    rd(1'b0, 8'hC3, "R6 release-cycle completion stored low");
    rd(1'b1, 8'h02, "R6 release-cycle completion stored high");

    rd(1'b1, 8'h02, "R7 high without low");
    conv(10'h1E7);
    rd(1'b0, 8'hE7, "R7 still open, new result stored");
    rd(1'b1, 8'h01, "R7 high of new result");

    repeat (3) @(negedge clk);
    check(rd_data == 8'h01, "R10 data held between reads", rd_data, 8'h01);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule